// File: doc/BRIEF.md
# Tile Conversion Sequencer

This block runs one tiled image conversion from start to finish. A frame too large for the scaling engine is cut into a grid of columns by rows. The sequencer hands those tiles to the conversion engine one at a time, in row-major order. For each tile it raises a load strobe that carries the source address and the destination address. The source address is a base plus the offset of the tile. The destination address is a base plus the offset of the destination tile, found through a remap table, because rotation and flipping reorder tiles. The strobe also carries a buffer index and a flag that tells the engine to stop and restart instead of only reloading addresses.

After each load the sequencer collects end-of-frame events. Input and output events are always needed. When a 90° rotation pass is used, the two rotation-channel events are needed too. Once every needed event has arrived, the sequencer issues the next tile or ends the run.

At the start of each run it decides once whether ping-pong buffering may be used. It looks at the planar flags and the tile count, and at whether all active tiles share one geometry and one set of scaling coefficients. An abort request stops the run at the next tile completion, unless ping-pong buffering is active. In that case the abort is ignored until the run ends normally.

Top module: `tile_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `ld_strobe`, `run_done` and `run_err` are all 0.
- R2: A `run_start` pulse while idle starts a run of N = `cfg_cols` × `cfg_rows` tiles. `cfg_cols` and `cfg_rows` must each be 1..MAX_STRIPES. One single-cycle `ld_strobe` is given per tile, for tiles 0..N-1 in order. `ld_src_addr` = `src_base` + source offset of tile t.
- R3: `ld_dst_addr` = `dst_base` + destination offset of tile m, where m is entry t of the remap table.
- R4: `eof_evt` has one bit per channel: bit 0 input, bit 1 output, bit 2 rotation input, bit 3 rotation output. A tile counts as complete once bits 0 and 1 have been seen, and also bits 2 and 3 when `cfg_rot90` is 1. Bits may arrive in different cycles. Bits that are not needed are ignored. Events are taken only while waiting for completion, not in the load cycle, and the seen-set clears at each load.
- R5: `dbl_mode` (ping-pong buffering) is 1 only if N > 1 and neither `src_planar` nor `dst_planar` is set. It holds for the whole run.
- R6: `dbl_mode` is 0 if any active tile (index < N) has a packed geometry word {in width, in height, out width, out height} that differs from tile 0. Entries at index N or above have no effect.
- R7: `dbl_mode` is 0 if any active column's horizontal coefficient differs from column 0, or any active row's vertical coefficient differs from row 0.
- R8: With `dbl_mode` set, `ld_buf` is 0 for tile 0 and toggles on every following load. Without it, `ld_buf` is always 0.
- R9: `ld_restart` is 1 for tile 0. For a later tile it is 1 only when `dbl_mode` is 0 and that tile's column or row coefficient differs from the previous tile's.
- R10: When the last tile completes, `run_done` pulses for exactly one cycle with `run_err` = 0, and the block returns to idle.
- R11: Without `dbl_mode`, an `abort_req` seen during a run ends it at the next tile completion. `run_done` pulses with `run_err` = 1 and no further tiles load.
- R12: With `dbl_mode`, `abort_req` has no effect and the run finishes with `run_err` = 0. `abort_req` while idle also has no effect.
- R13: `run_start` during a run is ignored. Tiles keep their order and no restart occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Start pulse, taken only when idle |
| abort_req | input | 1 | Abort request pulse |
| cfg_cols | input | STR_W | Number of tile columns |
| cfg_rows | input | STR_W | Number of tile rows |
| cfg_rot90 | input | 1 | Rotation pass in use; rotation EOFs are needed |
| src_planar | input | 1 | Source format is planar |
| dst_planar | input | 1 | Destination format is planar |
| src_base | input | ADDR_W | Source frame base address |
| dst_base | input | ADDR_W | Destination frame base address |
| src_off_tbl | input | MAX_TILES*OFF_W | Source tile offsets, tile t at bits [t*OFF_W +: OFF_W] |
| dst_off_tbl | input | MAX_TILES*OFF_W | Destination tile offsets |
| dst_map_tbl | input | MAX_TILES*IDX_W | Destination tile index for each source tile |
| geom_tbl | input | MAX_TILES*4*DIM_W | Packed per-tile geometry words |
| coef_h_tbl | input | MAX_STRIPES*COEF_W | Horizontal coefficient per column |
| coef_v_tbl | input | MAX_STRIPES*COEF_W | Vertical coefficient per row |
| eof_evt | input | 4 | End-of-frame event pulses |
| ld_strobe | output | 1 | Buffer load strobe |
| ld_tile | output | IDX_W | Source tile index being loaded |
| ld_buf | output | 1 | Buffer index for this load |
| ld_restart | output | 1 | Stop and restart the engine at this tile |
| ld_src_addr | output | ADDR_W | Source address of the tile |
| ld_dst_addr | output | ADDR_W | Destination address of the tile |
| busy | output | 1 | Run in progress |
| dbl_mode | output | 1 | Ping-pong buffering selected for the run |
| run_done | output | 1 | Run finished, one-cycle pulse |
| run_err | output | 1 | Run ended by abort, valid with run_done |

## Verification
The bench covers these corner cases:

- A perturbed geometry or coefficient entry that lies beyond the active tile count. A design that scanned the whole table would turn ping-pong buffering off without cause.
- Abort on the last tile without ping-pong buffering. A design that checked for run end before checking the abort would report success instead of the error.
- Abort under ping-pong buffering. A design that failed to defer the abort would cut the run short.
- EOF bits split across cycles, only input and output EOFs under rotation, EOFs arriving in the load cycle, and unneeded rotation bits. Each of these shows up as an early or duplicated tile completion.
- A coefficient column that changes back and forth. This exposes a restart flag compared against column 0 rather than the previous tile.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_t;

   localparam int EVT_W    = 4;
   localparam int EVT_IN   = 0;
   localparam int EVT_OUT  = 1;
   localparam int EVT_RIN  = 2;
   localparam int EVT_ROUT = 3;
endpackage

// File: rtl/tseq_dbl_check.sv
module tseq_dbl_check #(
   parameter int MAX_STRIPES = 4,
   parameter int MAX_TILES   = 16,
   parameter int CNT_W       = 5,
   parameter int STR_W       = 3,
   parameter int GEOM_W      = 48,
   parameter int COEF_W      = 14
) (
   input  logic [CNT_W-1:0]              tile_cnt,
   input  logic [STR_W-1:0]              cols,
   input  logic [STR_W-1:0]              rows,
   input  logic                          src_planar,
   input  logic                          dst_planar,
   input  logic [MAX_TILES*GEOM_W-1:0]   geom_tbl,
   input  logic [MAX_STRIPES*COEF_W-1:0] coef_h_tbl,
   input  logic [MAX_STRIPES*COEF_W-1:0] coef_v_tbl,
   output logic                          dbl_ok
);
   logic [MAX_TILES-1:0]   geom_bad;
   logic [MAX_STRIPES-1:0] h_bad;
   logic [MAX_STRIPES-1:0] v_bad;

   for (genvar t = 0; t < MAX_TILES; t++) begin : g_geom
      assign geom_bad[t] = (CNT_W'(t) < tile_cnt) &&
                           (geom_tbl[t*GEOM_W +: GEOM_W] != geom_tbl[0 +: GEOM_W]);
   end

   for (genvar s = 0; s < MAX_STRIPES; s++) begin : g_coef
      assign h_bad[s] = (STR_W'(s) < cols) &&
                        (coef_h_tbl[s*COEF_W +: COEF_W] != coef_h_tbl[0 +: COEF_W]);
      assign v_bad[s] = (STR_W'(s) < rows) &&
                        (coef_v_tbl[s*COEF_W +: COEF_W] != coef_v_tbl[0 +: COEF_W]);
   end

   assign dbl_ok = (tile_cnt > CNT_W'(1)) && !src_planar && !dst_planar &&
                   !(|geom_bad) && !(|h_bad) && !(|v_bad);
endmodule

// File: rtl/tseq_eof_collect.sv
module tseq_eof_collect
   import tseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             accept,
   input  logic             rot_en,
   input  logic [EVT_W-1:0] evt,
   output logic             tile_done
);
   logic [EVT_W-1:0] need;
   logic [EVT_W-1:0] seen;
   logic [EVT_W-1:0] merged;

   always_comb begin
      need           = '0;
      need[EVT_IN]   = 1'b1;
      need[EVT_OUT]  = 1'b1;
      need[EVT_RIN]  = rot_en;
      need[EVT_ROUT] = rot_en;
   end

   assign merged    = seen | (evt & need);
   assign tile_done = accept && ((merged & need) == need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen <= '0;
      else if (clr)    seen <= '0;
      else if (accept) seen <= merged;
   end

   assert_seen_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(seen) & ~seen) == '0));

   assert_rot_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_done && rot_en) |-> (seen[EVT_ROUT] || evt[EVT_ROUT]));
endmodule

// File: rtl/tseq_addr_gen.sv
module tseq_addr_gen #(
   parameter int MAX_TILES = 16,
   parameter int IDX_W     = 4,
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 24
) (
   input  logic [IDX_W-1:0]           tile,
   input  logic [ADDR_W-1:0]          src_base,
   input  logic [ADDR_W-1:0]          dst_base,
   input  logic [MAX_TILES*OFF_W-1:0] src_off_tbl,
   input  logic [MAX_TILES*OFF_W-1:0] dst_off_tbl,
   input  logic [MAX_TILES*IDX_W-1:0] dst_map_tbl,
   output logic [ADDR_W-1:0]          src_addr,
   output logic [ADDR_W-1:0]          dst_addr
);
   logic [IDX_W-1:0] dst_idx;

   assign dst_idx  = dst_map_tbl[int'(tile)*IDX_W +: IDX_W];
   assign src_addr = src_base + ADDR_W'(src_off_tbl[int'(tile)*OFF_W +: OFF_W]);
   assign dst_addr = dst_base + ADDR_W'(dst_off_tbl[int'(dst_idx)*OFF_W +: OFF_W]);
endmodule

// File: rtl/tile_seq_ctrl.sv
module tile_seq_ctrl
   import tseq_pkg::*;
#(
   parameter int MAX_STRIPES = 4,
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 24,
   parameter int DIM_W       = 12,
   parameter int COEF_W      = 14,
   localparam int MAX_TILES  = MAX_STRIPES * MAX_STRIPES,
   localparam int IDX_W      = $clog2(MAX_TILES),
   localparam int CNT_W      = $clog2(MAX_TILES + 1),
   localparam int STR_W      = $clog2(MAX_STRIPES + 1),
   localparam int GEOM_W     = 4 * DIM_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run_start,
   input  logic                          abort_req,
   input  logic [STR_W-1:0]              cfg_cols,
   input  logic [STR_W-1:0]              cfg_rows,
   input  logic                          cfg_rot90,
   input  logic                          src_planar,
   input  logic                          dst_planar,
   input  logic [ADDR_W-1:0]             src_base,
   input  logic [ADDR_W-1:0]             dst_base,
   input  logic [MAX_TILES*OFF_W-1:0]    src_off_tbl,
   input  logic [MAX_TILES*OFF_W-1:0]    dst_off_tbl,
   input  logic [MAX_TILES*IDX_W-1:0]    dst_map_tbl,
   input  logic [MAX_TILES*GEOM_W-1:0]   geom_tbl,
   input  logic [MAX_STRIPES*COEF_W-1:0] coef_h_tbl,
   input  logic [MAX_STRIPES*COEF_W-1:0] coef_v_tbl,
   input  logic [3:0]                    eof_evt,
   output logic                          ld_strobe,
   output logic [IDX_W-1:0]              ld_tile,
   output logic                          ld_buf,
   output logic                          ld_restart,
   output logic [ADDR_W-1:0]             ld_src_addr,
   output logic [ADDR_W-1:0]             ld_dst_addr,
   output logic                          busy,
   output logic                          dbl_mode,
   output logic                          run_done,
   output logic                          run_err
);
   if (MAX_STRIPES < 2) begin : g_bad_stripes
      $error("tile_seq_ctrl: MAX_STRIPES must be at least 2");
   end
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("tile_seq_ctrl: OFF_W must not exceed ADDR_W");
   end

   seq_state_t        state;
   logic [CNT_W-1:0]  next_tile, tile_cnt, start_cnt;
   logic [STR_W-1:0]  n_cols, col_idx, row_idx;
   logic              rot_r, dbl_r, buf_r, abort_pend;
   logic [COEF_W-1:0] prev_ch, prev_cv, cur_ch, cur_cv;
   logic              dbl_ok, tile_done, done_r, err_r;

   assign start_cnt = CNT_W'(cfg_cols) * CNT_W'(cfg_rows);
   assign cur_ch    = coef_h_tbl[int'(col_idx)*COEF_W +: COEF_W];
   assign cur_cv    = coef_v_tbl[int'(row_idx)*COEF_W +: COEF_W];

   tseq_dbl_check #(
      .MAX_STRIPES(MAX_STRIPES), .MAX_TILES(MAX_TILES), .CNT_W(CNT_W),
      .STR_W(STR_W), .GEOM_W(GEOM_W), .COEF_W(COEF_W)
   ) u_dbl (
      .tile_cnt(start_cnt), .cols(cfg_cols), .rows(cfg_rows),
      .src_planar(src_planar), .dst_planar(dst_planar),
      .geom_tbl(geom_tbl), .coef_h_tbl(coef_h_tbl), .coef_v_tbl(coef_v_tbl),
      .dbl_ok(dbl_ok)
   );

   tseq_eof_collect u_eof (
      .clk(clk), .rst_n(rst_n),
      .clr(state == ST_ISSUE), .accept(state == ST_WAIT),
      .rot_en(rot_r), .evt(eof_evt), .tile_done(tile_done)
   );

   tseq_addr_gen #(
      .MAX_TILES(MAX_TILES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
   ) u_addr (
      .tile(ld_tile), .src_base(src_base), .dst_base(dst_base),
      .src_off_tbl(src_off_tbl), .dst_off_tbl(dst_off_tbl),
      .dst_map_tbl(dst_map_tbl),
      .src_addr(ld_src_addr), .dst_addr(ld_dst_addr)
   );

   assign ld_strobe  = (state == ST_ISSUE);
   assign ld_tile    = next_tile[IDX_W-1:0];
   assign ld_buf     = buf_r;
   assign ld_restart = (next_tile == '0) ||
                       (!dbl_r && ((cur_ch != prev_ch) || (cur_cv != prev_cv)));
   assign busy       = (state != ST_IDLE);
   assign dbl_mode   = dbl_r;
   assign run_done   = done_r;
   assign run_err    = err_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         next_tile  <= '0;
         tile_cnt   <= '0;
         n_cols     <= '0;
         col_idx    <= '0;
         row_idx    <= '0;
         rot_r      <= 1'b0;
         dbl_r      <= 1'b0;
         buf_r      <= 1'b0;
         abort_pend <= 1'b0;
         prev_ch    <= '0;
         prev_cv    <= '0;
         done_r     <= 1'b0;
         err_r      <= 1'b0;
      end else begin
         done_r <= 1'b0;
         err_r  <= 1'b0;
         if (busy && abort_req) abort_pend <= 1'b1;
         unique case (state)
            ST_IDLE: if (run_start) begin
               state      <= ST_ISSUE;
               next_tile  <= '0;
               tile_cnt   <= start_cnt;
               n_cols     <= cfg_cols;
               col_idx    <= '0;
               row_idx    <= '0;
               rot_r      <= cfg_rot90;
               dbl_r      <= dbl_ok;
               buf_r      <= 1'b0;
               abort_pend <= 1'b0;
            end
            ST_ISSUE: begin
               state     <= ST_WAIT;
               next_tile <= next_tile + CNT_W'(1);
               prev_ch   <= cur_ch;
               prev_cv   <= cur_cv;
               if (dbl_r) buf_r <= ~buf_r;
               if (col_idx == n_cols - STR_W'(1)) begin
                  col_idx <= '0;
                  row_idx <= row_idx + STR_W'(1);
               end else begin
                  col_idx <= col_idx + STR_W'(1);
               end
            end
            ST_WAIT: if (tile_done) begin
               if ((abort_pend || abort_req) && !dbl_r) begin
                  state  <= ST_IDLE;
                  done_r <= 1'b1;
                  err_r  <= 1'b1;
               end else if (next_tile == tile_cnt) begin
                  state  <= ST_IDLE;
                  done_r <= 1'b1;
               end else begin
                  state <= ST_ISSUE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe |=> !ld_strobe);

   assert_tile_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe |-> (next_tile < tile_cnt));

   assert_dbl_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(dbl_mode));

   assert_dbl_multi_tile_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dbl_mode) |-> (tile_cnt > CNT_W'(1)));

   assert_buf_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_strobe && !dbl_mode) |-> !ld_buf);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run_done |=> !run_done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run_done |-> !busy);

   assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      run_err |-> run_done);
endmodule

// File: tb/sim_tile_seq_ctrl.sv
module sim_tile_seq_ctrl;
   localparam int MAX_STRIPES = 4;
   localparam int ADDR_W      = 32;
   localparam int OFF_W       = 24;
   localparam int DIM_W       = 12;
   localparam int COEF_W      = 14;
   localparam int MAX_TILES   = MAX_STRIPES * MAX_STRIPES;
   localparam int IDX_W       = $clog2(MAX_TILES);
   localparam int STR_W       = $clog2(MAX_STRIPES + 1);
   localparam int GEOM_W      = 4 * DIM_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                          run_start = 1'b0, abort_req = 1'b0;
   logic [STR_W-1:0]              cfg_cols = '0, cfg_rows = '0;
   logic                          cfg_rot90 = 1'b0, src_planar = 1'b0, dst_planar = 1'b0;
   logic [ADDR_W-1:0]             src_base = '0, dst_base = '0;
   logic [MAX_TILES*OFF_W-1:0]    src_off_tbl = '0, dst_off_tbl = '0;
   logic [MAX_TILES*IDX_W-1:0]    dst_map_tbl = '0;
   logic [MAX_TILES*GEOM_W-1:0]   geom_tbl = '0;
   logic [MAX_STRIPES*COEF_W-1:0] coef_h_tbl = '0, coef_v_tbl = '0;
   logic [3:0]                    eof_evt = '0;
   logic                          ld_strobe, ld_buf, ld_restart, busy, dbl_mode, run_done, run_err;
   logic [IDX_W-1:0]              ld_tile;
   logic [ADDR_W-1:0]             ld_src_addr, ld_dst_addr;

   tile_seq_ctrl #(
      .MAX_STRIPES(MAX_STRIPES), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
      .DIM_W(DIM_W), .COEF_W(COEF_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .abort_req(abort_req),
      .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_rot90(cfg_rot90),
      .src_planar(src_planar), .dst_planar(dst_planar),
      .src_base(src_base), .dst_base(dst_base),
      .src_off_tbl(src_off_tbl), .dst_off_tbl(dst_off_tbl), .dst_map_tbl(dst_map_tbl),
      .geom_tbl(geom_tbl), .coef_h_tbl(coef_h_tbl), .coef_v_tbl(coef_v_tbl),
      .eof_evt(eof_evt),
      .ld_strobe(ld_strobe), .ld_tile(ld_tile), .ld_buf(ld_buf), .ld_restart(ld_restart),
      .ld_src_addr(ld_src_addr), .ld_dst_addr(ld_dst_addr),
      .busy(busy), .dbl_mode(dbl_mode), .run_done(run_done), .run_err(run_err)
   );

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;
   int  cols = 1, rows = 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [COEF_W-1:0] ch_of(input int c);
      return coef_h_tbl[c*COEF_W +: COEF_W];
   endfunction
   function automatic logic [COEF_W-1:0] cv_of(input int r);
      return coef_v_tbl[r*COEF_W +: COEF_W];
   endfunction

   function automatic bit exp_dbl();
      int cnt = cols * rows;
      bit ok = (cnt > 1) && !src_planar && !dst_planar;
      for (int i = 1; i < cnt; i++)
         if (geom_tbl[i*GEOM_W +: GEOM_W] != geom_tbl[0 +: GEOM_W]) ok = 1'b0;
      for (int c = 1; c < cols; c++) if (ch_of(c) != ch_of(0)) ok = 1'b0;
      for (int r = 1; r < rows; r++) if (cv_of(r) != cv_of(0)) ok = 1'b0;
      return ok;
   endfunction

   // pmode: 0 uniform, 1 geometry of tile p, 2 h coef of column p, 3 v coef of row p
   task automatic gen_tables(input int pmode, input int p);
      logic [GEOM_W-1:0] g0;
      logic [COEF_W-1:0] h0, v0;
      g0 = {$urandom, $urandom};
      h0 = COEF_W'($urandom);
      v0 = COEF_W'($urandom);
      src_base = $urandom;
      dst_base = $urandom;
      for (int i = 0; i < MAX_TILES; i++) begin
         src_off_tbl[i*OFF_W +: OFF_W] = OFF_W'($urandom);
         dst_off_tbl[i*OFF_W +: OFF_W] = OFF_W'($urandom);
         dst_map_tbl[i*IDX_W +: IDX_W] = IDX_W'($urandom);
         geom_tbl[i*GEOM_W +: GEOM_W]  = g0;
      end
      for (int s = 0; s < MAX_STRIPES; s++) begin
         coef_h_tbl[s*COEF_W +: COEF_W] = h0;
         coef_v_tbl[s*COEF_W +: COEF_W] = v0;
      end
      case (pmode)
         1: geom_tbl[(p % MAX_TILES)*GEOM_W +: GEOM_W] = g0 ^ GEOM_W'(1);
         2: coef_h_tbl[(p % MAX_STRIPES)*COEF_W +: COEF_W] = h0 ^ COEF_W'(1);
         3: coef_v_tbl[(p % MAX_STRIPES)*COEF_W +: COEF_W] = v0 ^ COEF_W'(1);
         default: ;
      endcase
   endtask

   task automatic do_run(input int abort_tile, input bit start_mid, input bit probe_issue);
      int cnt = cols * rows;
      bit xd, ab = 1'b0, fin = 1'b0;
      int k = 0;
      logic [3:0] req, part, junk;
      cfg_cols = STR_W'(cols);
      cfg_rows = STR_W'(rows);
      xd  = exp_dbl();
      req = cfg_rot90 ? 4'b1111 : 4'b0011;
      @(negedge clk); run_start = 1'b1;
      @(negedge clk); run_start = 1'b0;
      while (!fin) begin
         int c = k % cols, r = k / cols;
         logic [ADDR_W-1:0] es, ed;
         bit er;
         int m = int'(dst_map_tbl[k*IDX_W +: IDX_W]);
         es = src_base + ADDR_W'(src_off_tbl[k*OFF_W +: OFF_W]);
         ed = dst_base + ADDR_W'(dst_off_tbl[m*OFF_W +: OFF_W]);
         er = (k == 0) || (!xd && ((ch_of(c) != ch_of((k-1) % cols)) ||
                                   (cv_of(r) != cv_of((k-1) / cols))));
         chk(ld_strobe === 1'b1, "R2", "load strobe", ld_strobe, 1);
         chk(ld_tile == IDX_W'(k), "R2 R13", "tile index", ld_tile, k);
         chk(ld_src_addr == es, "R2", "source address", ld_src_addr, es);
         chk(ld_dst_addr == ed, "R3", "remapped destination address", ld_dst_addr, ed);
         chk(dbl_mode == xd, "R5 R6 R7", "double buffer mode", dbl_mode, xd);
         chk(ld_buf == (xd ? k[0] : 1'b0), "R8", "buffer index", ld_buf, xd ? k[0] : 1'b0);
         chk(ld_restart == er, "R9", "restart flag", ld_restart, er);
         eof_evt = (probe_issue && k == 0) ? req : 4'b0000;
         @(negedge clk);
         if (probe_issue && k == 0)
            chk(!ld_strobe && !run_done, "R4", "events in load cycle ignored",
                {ld_strobe, run_done}, 0);
         junk = cfg_rot90 ? 4'b0000 : (4'($urandom) & 4'b1100);
         part = req & 4'($urandom) & 4'b1110;
         if (cfg_rot90 && k == 0) part = 4'b0011;
         eof_evt = part | junk;
         if (k == abort_tile) begin abort_req = 1'b1; ab = 1'b1; end
         if (start_mid && k == 1) run_start = 1'b1;
         @(negedge clk);
         chk(!ld_strobe && !run_done, "R4", "incomplete event set", {ld_strobe, run_done}, 0);
         eof_evt   = (req & ~part) | (cfg_rot90 ? 4'b0000 : (4'($urandom) & 4'b1100));
         abort_req = 1'b0;
         run_start = 1'b0;
         @(negedge clk);
         eof_evt = 4'b0000;
         if (ab && !xd) begin
            chk(run_done && run_err && !ld_strobe, "R11", "abort ends run with error",
                {run_done, run_err, ld_strobe}, 3'b110);
            fin = 1'b1;
         end else if (k == cnt - 1) begin
            chk(run_done && !run_err && !ld_strobe, ab ? "R12" : "R10", "run success",
                {run_done, run_err, ld_strobe}, 3'b100);
            fin = 1'b1;
         end else begin
            k++;
         end
      end
      @(negedge clk);
      chk(!run_done && !busy, "R10", "single done pulse then idle", {run_done, busy}, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(!busy && !ld_strobe && !run_done && !run_err, "R1", "reset state",
          {busy, ld_strobe, run_done, run_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !ld_strobe && !run_done, "R1", "idle after reset release",
          {busy, ld_strobe, run_done}, 0);

      // abort while idle has no effect
      abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
      chk(!busy && !run_done, "R12", "idle abort ignored", {busy, run_done}, 0);
      cols = 1; rows = 1; gen_tables(0, 0);
      do_run(-1, 1'b0, 1'b1);

      // uniform 2x2, rotation, abort deferred by double buffering
      cols = 2; rows = 2; cfg_rot90 = 1'b1; gen_tables(0, 0);
      do_run(1, 1'b0, 1'b0);
      // same but planar source: abort honoured
      src_planar = 1'b1; gen_tables(0, 0);
      do_run(1, 1'b0, 1'b0);
      src_planar = 1'b0; dst_planar = 1'b1;
      do_run(-1, 1'b0, 1'b0);
      dst_planar = 1'b0; cfg_rot90 = 1'b0;
      // perturbation beyond active tiles is irrelevant (R6)
      cols = 4; rows = 2; gen_tables(1, 12);
      do_run(-1, 1'b1, 1'b0);
      // active geometry mismatch (R6)
      cols = 2; rows = 2; gen_tables(1, 3);
      do_run(-1, 1'b0, 1'b0);
      // column coefficient mismatch, restarts (R7, R9)
      cols = 4; rows = 1; gen_tables(2, 2);
      do_run(-1, 1'b0, 1'b0);
      cols = 1; rows = 4; gen_tables(3, 1);
      do_run(-1, 1'b0, 1'b0);
      // abort on last tile without double buffering (R11)
      cols = 2; rows = 2; gen_tables(2, 1);
      do_run(3, 1'b0, 1'b0);

      for (int n = 0; n < 40; n++) begin
         int cnt;
         cols = 1 + int'($urandom % MAX_STRIPES);
         rows = 1 + int'($urandom % MAX_STRIPES);
         cnt  = cols * rows;
         cfg_rot90  = ($urandom % 2) == 0;
         src_planar = ($urandom % 4) == 0;
         dst_planar = ($urandom % 4) == 0;
         gen_tables(int'($urandom % 4), int'($urandom % MAX_TILES));
         do_run((($urandom % 3) == 0) ? int'($urandom % cnt) : -1,
                ($urandom % 4) == 0, ($urandom % 4) == 0);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end
endmodule